// File: doc/BRIEF.md
# I2C Register Access Port

This block is the target side of an I2C link in front of a small bank of 8-bit registers. It takes the SCL and SDA pad inputs, which are sampled by the much faster system clock. It suppresses short spikes on both lines and finds START and STOP conditions. It then compares the first byte of each transfer with a 7-bit address that two four-level strap inputs select. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

A write transfer carries a command byte first, and that byte loads the register pointer. Each following byte goes out on a one-cycle write strobe with the pointer as the register address. A read transfer fetches bytes from the pointer with a one-cycle read strobe, so the register bank can trigger side effects on read, such as clearing status. It shifts each byte out MSB first until the master answers with a NACK. The pointer moves on after every data byte and is kept from one transfer to the next.

Top module: `i2c_reg_port`

## Requirements
- R1: Any pulse shorter than FILT_LEN system clocks on SCL or SDA is ignored. It neither clocks a bit nor forms a START or STOP condition.
- R2: Each strap pin takes a 2-bit level code (0 = ground, 1 = supply, 2 = tied to SCL, 3 = tied to SDA). The 7-bit address for the pair (upper strap, lower strap) is 0x10/0x11/0x12/0x13 for (SCL,GND)/(SCL,VCC)/(SDA,GND)/(SDA,VCC). It is 0x18/0x19/0x1A/0x1B for (SCL,SCL)/(SCL,SDA)/(SDA,SCL)/(SDA,SDA). It is 0x20/0x21/0x22/0x23 for (GND,GND)/(GND,VCC)/(VCC,GND)/(VCC,VCC). It is 0x28/0x29/0x2A/0x2B for (GND,SCL)/(GND,SDA)/(VCC,SCL)/(VCC,SDA).
- R3: START (SDA falls while SCL is high) begins a transfer, including a repeated START in the middle of one. STOP (SDA rises while SCL is high) ends it. Bytes clocked after a STOP and without a new START get no acknowledge and cause no register access.
- R4: An address byte whose upper 7 bits match the strap address is acknowledged by driving SDA low for the ninth clock. On a mismatch SDA is left released, and the rest of the transfer is ignored. The command byte and each write data byte are also acknowledged.
- R5: In a write (bit 0 of the address byte = 0), the byte after the address loads the pointer. Each later byte raises reg_wr_en for one clock, with reg_addr set to the pointer and reg_wdata set to the byte.
- R6: The pointer moves up by one after every data byte written or read, and it goes from LAST_REG (default 0x0A) back to 0x00.
- R7: In a read (bit 0 = 1), each byte is fetched with a one-clock reg_rd_en pulse at reg_addr and shifted out MSB first. A master ACK fetches the next byte. A master NACK ends the fetching.
- R8: The pointer resets to 0x00. A read with no command byte before it starts at the pointer left by the last access.
- R9: After reset sda_oe, reg_wr_en and reg_rd_en are low. While no transfer is active, sda_oe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input (wired-AND bus level) |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| strap_hi | input | 2 | Level code of the upper address strap |
| strap_lo | input | 2 | Level code of the lower address strap |
| reg_wr_en | output | 1 | One-clock register write strobe |
| reg_rd_en | output | 1 | One-clock register read strobe |
| reg_addr | output | PTR_W | Register address for either strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid while reg_rd_en is high |

## Verification
Some properties are checked by assertions on every cycle. Both strobes are single-cycle and never high together. A filtered line only changes to a value that the synchronised input has already held. The bus stays released while idle. The pointer falls to zero after LAST_REG is read. An address acknowledge only starts after a matching byte. Other behaviour can only be shown by the directed scenarios. These cover the full strap-to-address table, the data that lands in the register bank for command and burst writes, read data order across ACK and NACK, the pointer kept between transfers, and the rejection of spikes and of bytes sent without a START.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] LVL_GND = 2'd0;
  localparam logic [1:0] LVL_VCC = 2'd1;
  localparam logic [1:0] LVL_SCL = 2'd2;
  localparam logic [1:0] LVL_SDA = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX_LOAD,
    ST_TXDATA,
    ST_TX_ACK
  } eng_state_t;
endpackage

// File: rtl/i2ct_glitch_filter.sv
module i2ct_glitch_filter #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      dout   <= 1'b1;
      cnt    <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        dout <= sync_q[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: filtered level only ever takes a value already present on the synchronised input
  p_filter_settled_r1: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(sync_q[1])));
endmodule

// File: rtl/i2ct_addr_map.sv
module i2ct_addr_map
  import i2ct_pkg::*;
(
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  output logic [6:0] addr
);
  logic hi_bus, lo_bus, hi_up, lo_up;

  always_comb begin
    hi_bus = (strap_hi == LVL_SCL) || (strap_hi == LVL_SDA);
    lo_bus = (strap_lo == LVL_SCL) || (strap_lo == LVL_SDA);
    hi_up  = (strap_hi == LVL_VCC) || (strap_hi == LVL_SDA);
    lo_up  = (strap_lo == LVL_VCC) || (strap_lo == LVL_SDA);
    unique case ({hi_bus, lo_bus})
      2'b10:   addr = 7'h10;
      2'b11:   addr = 7'h18;
      2'b00:   addr = 7'h20;
      default: addr = 7'h28;
    endcase
    addr[1] = hi_up;
    addr[0] = lo_up;
  end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter logic [PTR_W-1:0] LAST_REG = 'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [6:0]        own_addr,
  output logic              sda_oe,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  eng_state_t        state;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic [3:0]        rx_cnt;
  logic [2:0]        tx_cnt;
  logic              rw_bit, m_ack;
  logic [PTR_W-1:0]  ptr;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == LAST_REG) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sda_oe    <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_cnt    <= '0;
      tx_cnt    <= '0;
      rw_bit    <= 1'b0;
      m_ack     <= 1'b0;
      ptr       <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (start_c) begin
        state  <= ST_ADDR;
        rx_cnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && rx_cnt != 4'd8) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda};
              rx_cnt <= rx_cnt + 4'd1;
            end else if (scl_fall && rx_cnt == 4'd8) begin
              rx_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[7:1] == own_addr) begin
                  sda_oe <= 1'b1;
                  rw_bit <= rx_sh[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                ptr    <= PTR_W'(rx_sh);
                sda_oe <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                reg_wr_en <= 1'b1;
                reg_addr  <= ptr;
                reg_wdata <= rx_sh;
                ptr       <= ptr_step(ptr);
                sda_oe    <= 1'b1;
                state     <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (rw_bit) begin
                reg_rd_en <= 1'b1;
                reg_addr  <= ptr;
                state     <= ST_TX_LOAD;
              end else begin
                state <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_TX_LOAD: begin
            tx_sh  <= reg_rdata;
            sda_oe <= ~reg_rdata[BYTE_W-1];
            tx_cnt <= '0;
            ptr    <= ptr_step(ptr);
            state  <= ST_TXDATA;
          end
          ST_TXDATA: begin
            if (scl_fall) begin
              if (tx_cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_cnt <= tx_cnt + 3'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda;
            end else if (scl_fall) begin
              if (m_ack) begin
                reg_rd_en <= 1'b1;
                reg_addr  <= ptr;
                state     <= ST_TX_LOAD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: write strobe lasts one clock
  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);
  // R7: read strobe lasts one clock and never overlaps a write
  p_rd_single_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_en && reg_wr_en));
  // R6: reading the last register brings the pointer back to zero
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_LOAD && ptr == LAST_REG && !start_c && !stop_c) |=> (ptr == '0));
  // R9: bus released while no transfer is active
  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R4: address acknowledge only after a matching byte
  p_ack_match_r4: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe) && state == ST_ADDR_ACK) |-> (rx_sh[7:1] == own_addr));
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2ct_pkg::*;
#(
  parameter int FILT_LEN = 10,
  parameter int PTR_W = 8,
  parameter logic [PTR_W-1:0] LAST_REG = 'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_hi,
  input  logic [1:0]        strap_lo,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic [6:0]         own_addr;

  assign raw_lines = {sda_i, scl_i};

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_filt
    i2ct_glitch_filter #(.LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lines[gi]),
      .dout (clean_lines[gi])
    );
  end

  i2ct_addr_map u_map (
    .strap_hi (strap_hi),
    .strap_lo (strap_lo),
    .addr     (own_addr)
  );

  i2ct_engine #(.PTR_W(PTR_W), .LAST_REG(LAST_REG)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl       (clean_lines[0]),
    .sda       (clean_lines[1]),
    .own_addr  (own_addr),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: tb/tb_i2c_reg_port.sv
module tb_i2c_reg_port;
  localparam int Q = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] s_hi = 2'd0, s_lo = 2'd0;
  logic       sda_oe, reg_wr_en, reg_rd_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [0:15];
  int         wr_cnt = 0, rd_cnt = 0;
  int         checks = 0, errors = 0;
  wire        sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_reg_port dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_hi(s_hi), .strap_lo(s_lo), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 17 + 3);
  endfunction

  assign reg_rdata = mem[reg_addr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_wr_en) begin
        mem[reg_addr[3:0]] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic logic [6:0] exp_addr(input logic [1:0] h, input logic [1:0] l);
    case ({h, l})
      4'b10_00: return 7'h10;  4'b10_01: return 7'h11;
      4'b11_00: return 7'h12;  4'b11_01: return 7'h13;
      4'b10_10: return 7'h18;  4'b10_11: return 7'h19;
      4'b11_10: return 7'h1A;  4'b11_11: return 7'h1B;
      4'b00_00: return 7'h20;  4'b00_01: return 7'h21;
      4'b01_00: return 7'h22;  4'b01_01: return 7'h23;
      4'b00_10: return 7'h28;  4'b00_11: return 7'h29;
      4'b01_10: return 7'h2A;  default:  return 7'h2B;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(2*Q); m_sda = 1'b0; wc(2*Q); m_scl = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wc(Q); m_scl = 1'b1; wc(2*Q); m_sda = 1'b1; wc(2*Q);
  endtask

  task automatic put_bit(input logic b, input bit scl_spk, input bit sda_spk);
    m_sda = b;
    wc(Q/2);
    if (scl_spk) begin m_scl = 1'b1; wc(4); m_scl = 1'b0; wc(Q/2 - 4); end
    else wc(Q/2);
    m_scl = 1'b1;
    if (sda_spk) begin wc(Q/2); m_sda = ~b; wc(4); m_sda = b; wc(Q/2 - 4); end
    else wc(Q);
    m_scl = 1'b0; wc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int spk_bit, input bit spk_sda,
                           output bit acked);
    for (int i = 7; i >= 0; i--)
      put_bit(b[i], (spk_bit == i) && !spk_sda, (spk_bit == i) && spk_sda);
    m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(Q);
    acked = !sda_line;
    wc(Q); m_scl = 1'b0; wc(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(Q);
      b[i] = sda_line;
      wc(Q); m_scl = 1'b0; wc(Q);
    end
    m_sda = ~give_ack; wc(Q); m_scl = 1'b1; wc(2*Q); m_scl = 1'b0; wc(Q);
  endtask

  // R9: idle outputs after reset
  task automatic t_reset();
    chk("R9 sda_oe after reset", sda_oe, 0);
    chk("R9 reg_wr_en after reset", reg_wr_en, 0);
    chk("R9 reg_rd_en after reset", reg_rd_en, 0);
  endtask

  // R8: first read with no command byte starts at register 0
  task automatic t_read_from_reset();
    bit a; logic [7:0] d;
    s_hi = 2'd0; s_lo = 2'd0; wc(4);
    bus_start(); send_byte({7'h20, 1'b1}, -1, 0, a); recv_byte(0, d); bus_stop();
    chk("R8 read ack", a, 1);
    chk("R8 data from reset pointer", d, init_val(0));
    chk("R7 one read strobe", rd_cnt, 1);
  endtask

  // R2/R4: every strap pair, plus a mismatching address
  task automatic t_addr_map();
    bit a; int w0;
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++) begin
        s_hi = 2'(h); s_lo = 2'(l); wc(4);
        bus_start(); send_byte({exp_addr(2'(h), 2'(l)), 1'b0}, -1, 0, a); bus_stop();
        chk($sformatf("R2 ack for straps %0d/%0d", h, l), a, 1);
      end
    s_hi = 2'd0; s_lo = 2'd0; wc(4);
    w0 = wr_cnt;
    bus_start(); send_byte({7'h21, 1'b0}, -1, 0, a);
    chk("R4 nack on mismatch", a, 0);
    send_byte(8'h01, -1, 0, a); send_byte(8'hEE, -1, 0, a); bus_stop();
    chk("R4 no write after mismatch", wr_cnt - w0, 0);
    chk("R4 register untouched", mem[1], init_val(1));
  endtask

  task automatic wr_seq(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, output bit all_ack);
    bit a0, a1, a2, a3, a4;
    bus_start();
    send_byte({7'h20, 1'b0}, -1, 0, a0); send_byte(cmd, -1, 0, a1);
    send_byte(d0, -1, 0, a2); send_byte(d1, -1, 0, a3); send_byte(d2, -1, 0, a4);
    bus_stop();
    all_ack = a0 & a1 & a2 & a3 & a4;
  endtask

  // R5/R4: command byte then burst of writes
  task automatic t_write();
    bit ak; int w0 = wr_cnt;
    wr_seq(8'h03, 8'hA1, 8'hB2, 8'hC3, ak);
    chk("R4 all write bytes acked", ak, 1);
    chk("R5 reg3", mem[3], 8'hA1);
    chk("R5 reg4", mem[4], 8'hB2);
    chk("R5 reg5", mem[5], 8'hC3);
    chk("R5 write strobes", wr_cnt - w0, 3);
  endtask

  // R6: pointer wraps after the last register
  task automatic t_wrap();
    bit ak;
    wr_seq(8'h09, 8'h11, 8'h22, 8'h33, ak);
    chk("R6 reg9", mem[9], 8'h11);
    chk("R6 reg10", mem[10], 8'h22);
    chk("R6 wrapped to reg0", mem[0], 8'h33);
    chk("R6 reg11 untouched", mem[11], init_val(11));
  endtask

  // R7/R3: command, repeated START, read three bytes
  task automatic t_read_cmd();
    bit a0, a1, a2; logic [7:0] d0, d1, d2; int r0 = rd_cnt;
    bus_start(); send_byte({7'h20, 1'b0}, -1, 0, a0); send_byte(8'h02, -1, 0, a1);
    bus_start(); send_byte({7'h20, 1'b1}, -1, 0, a2);
    recv_byte(1, d0); recv_byte(1, d1); recv_byte(0, d2); bus_stop();
    chk("R3 ack after repeated start", a2, 1);
    chk("R7 byte0", d0, init_val(2));
    chk("R7 byte1", d1, 8'hA1);
    chk("R7 byte2", d2, 8'hB2);
    chk("R7 strobes stop at nack", rd_cnt - r0, 3);
  endtask

  // R8: read without a command continues at the kept pointer
  task automatic t_read_nocmd();
    bit a; logic [7:0] d;
    bus_start(); send_byte({7'h20, 1'b1}, -1, 0, a); recv_byte(0, d); bus_stop();
    chk("R8 continues at reg5", d, 8'hC3);
  endtask

  // R1: short spikes on both lines are ignored
  task automatic t_spike();
    bit a0, a1, a2;
    bus_start();
    send_byte({7'h20, 1'b0}, -1, 0, a0);
    send_byte(8'h06, 3, 1, a1);
    send_byte(8'h5A, 4, 0, a2);
    bus_stop();
    chk("R1 acks through spikes", a0 & a1 & a2, 1);
    chk("R1 reg6 written", mem[6], 8'h5A);
    chk("R1 reg7 untouched", mem[7], init_val(7));
  endtask

  // R3: bytes without a START after STOP are ignored
  task automatic t_no_start();
    bit a; int w0 = wr_cnt;
    send_byte({7'h20, 1'b0}, -1, 0, a);
    chk("R3 no ack without start", a, 0);
    send_byte(8'h08, -1, 0, a); send_byte(8'h77, -1, 0, a); bus_stop();
    chk("R3 no write without start", wr_cnt - w0, 0);
    chk("R3 reg8 untouched", mem[8], init_val(8));
  endtask

  initial begin
    wc(5); rst = 1'b0; wc(2);
    t_reset();
    t_read_from_reset();
    t_addr_map();
    t_write();
    t_wrap();
    t_read_cmd();
    t_read_nocmd();
    t_spike();
    t_no_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule